// File: doc/BRIEF.md
# Random Generator Status and Interrupt Register

This block is the status word of a random number generator. It reports three things: whether a fresh random sample is waiting in the output buffer, whether the clock checker currently sees a fault, and whether the seed health monitor currently sees a fault. Each fault source also has a sticky flag. The flag is raised on the clock edge where the fault first appears, and it stays high until software writes a 0 to its bit. A single interrupt line combines the ready bit and the two sticky flags, and an interrupt enable gates it.

The ready bit is kept by a two-state machine. In state `RDY_EMPTY`, the transition LOAD (a new-sample strobe) moves it to `RDY_FULL`. In `RDY_FULL`, the transition DRAIN (a data-register read with no new sample in the same cycle) returns it to `RDY_EMPTY`. REFILL covers a read and a new sample in the same cycle: the machine stays in `RDY_FULL`, because the new value refills the buffer. No generator-enable signal reaches this machine. Ready therefore rises whenever a sample arrives, even while the generator is switched off. The clock-fault input is masked while clock-fault detection is disabled.

Top module: `rng_stat_reg`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rd_data` is all zeros and `irq` is 0, whatever the other inputs do.
- R2: Bit 1 of `rd_data` shows, one cycle late, the masked clock fault (`clk_err_in` and not `ced_off`). Bit 2 shows, one cycle late, `seed_err_in`. A write has no effect on either bit.
- R3: Bit 3 (clock flag) and bit 4 (seed flag) go high on the same clock edge on which bit 1 or bit 2, respectively, rises from 0 to 1.
- R4: A write (`wr_en`=1) whose data holds 0 at bit 3 or bit 4 clears that flag. A write that holds 1 there leaves the flag unchanged. With `wr_en`=0 the data is ignored. Write data in bits 0, 1, 2 and 5 to 7 has no effect on any bit.
- R5: When a flag's set event and a clearing write fall in the same cycle, the flag ends up at 1.
- R6: While `ced_off`=1, bit 1 reads 0 from the next cycle on, and the clock flag cannot be set.
- R7: Bit 0 (ready) becomes 1 in the cycle after `sample_stb`=1, whatever `irq_en` and the other inputs are. It then holds until it is drained.
- R8: If `data_rd`=1 and `sample_stb`=0 while ready is 1, ready is 0 in the next cycle. If both are 1 in the same cycle, ready stays 1.
- R9: `irq` equals `irq_en` AND (bit 0 OR bit 3 OR bit 4) of the current register state. It follows `irq_en` with no delay.
- R10: A flag is set only on a rising fault, not while the fault is held. After a fault that is held steady has been cleared by a write, the flag stays 0 until the fault drops and rises again.
- R11: Bits 5 to 7 of `rd_data` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_err_in | input | 1 | Live fault level from the clock checker |
| seed_err_in | input | 1 | Live fault level from the seed health monitor |
| ced_off | input | 1 | 1 disables clock-fault detection |
| sample_stb | input | 1 | A new random value was written into the output buffer |
| data_rd | input | 1 | The data register is being read |
| irq_en | input | 1 | Interrupt enable |
| wr_en | input | 1 | Write strobe for the status register |
| wr_data | input | 8 | Write data; a 0 at bit 3 or bit 4 clears the matching flag |
| rd_data | output | 8 | Status word: 0 ready, 1 clock fault, 2 seed fault, 3 clock flag, 4 seed flag |
| irq | output | 1 | Interrupt request |

## Verification
The main input space is swept completely. Every one of the 1024 combinations of the two fault levels, the detect-disable bit, sample, read, interrupt enable, write strobe and three write-data bits is applied. The sweep runs twice, once in a strided order and once in Gray-code order. The strided order puts unrelated patterns next to each other, which exposes faults on held or rising levels. The Gray order changes one input per step, which isolates each single input's effect on the ready machine and the flags. Directed sequences then separate a held fault from a rising one, a clear that coincides with a set, a read that coincides with a sample, and a masked clock fault.

// File: rtl/rng_stat_pkg.sv
package rng_stat_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_SRC   = 2;
    localparam int SRC_CLK   = 0;
    localparam int SRC_SEED  = 1;
    localparam int RDY_BIT   = 0;
    localparam int LIVE_BASE = 1;
    localparam int FLAG_BASE = LIVE_BASE + NUM_SRC;

    typedef enum logic {
        RDY_EMPTY = 1'b0,
        RDY_FULL  = 1'b1
    } rdy_state_t;
endpackage

// File: rtl/rng_sticky_flag.sv
module rng_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic cond_i,
    input  logic clr_i,
    output logic live_o,
    output logic flag_o
);
    logic live_q;
    logic flag_q;
    logic set_ev;

    // set event: condition present now, absent in the previous cycle
    always_comb set_ev = cond_i && !live_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            live_q <= cond_i;
            if (set_ev)
                flag_q <= 1'b1;
            else if (clr_i)
                flag_q <= 1'b0;
        end
    end

    always_comb begin
        live_o = live_q;
        flag_o = flag_q;
    end
endmodule

// File: rtl/rng_ready_fsm.sv
module rng_ready_fsm
    import rng_stat_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_i,
    input  logic read_i,
    output logic ready_o
);
    rdy_state_t st_q;
    rdy_state_t st_d;

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= RDY_EMPTY;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RDY_EMPTY: if (sample_i) st_d = RDY_FULL;             // LOAD
            RDY_FULL:  if (read_i && !sample_i) st_d = RDY_EMPTY; // DRAIN (REFILL stays)
            default:   st_d = RDY_EMPTY;
        endcase
    end

    always_comb ready_o = (st_q == RDY_FULL);
endmodule

// File: rtl/rng_stat_reg.sv
module rng_stat_reg
    import rng_stat_pkg::*;
#(
    parameter int REG_W_P = REG_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_err_in,
    input  logic               seed_err_in,
    input  logic               ced_off,
    input  logic               sample_stb,
    input  logic               data_rd,
    input  logic               irq_en,
    input  logic               wr_en,
    input  logic [REG_W_P-1:0] wr_data,
    output logic [REG_W_P-1:0] rd_data,
    output logic               irq
);
    logic [NUM_SRC-1:0] cond;
    logic [NUM_SRC-1:0] live;
    logic [NUM_SRC-1:0] flag;
    logic               ready;

    always_comb begin
        cond[SRC_CLK]  = clk_err_in && !ced_off;
        cond[SRC_SEED] = seed_err_in;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rng_sticky_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .cond_i (cond[i]),
            .clr_i  (wr_en && !wr_data[FLAG_BASE+i]),
            .live_o (live[i]),
            .flag_o (flag[i])
        );
    end

    rng_ready_fsm u_rdy (
        .clk      (clk),
        .rst      (rst),
        .sample_i (sample_stb),
        .read_i   (data_rd),
        .ready_o  (ready)
    );

    always_comb begin
        rd_data = '0;
        rd_data[RDY_BIT] = ready;
        for (int i = 0; i < NUM_SRC; i++) begin
            rd_data[LIVE_BASE+i] = live[i];
            rd_data[FLAG_BASE+i] = flag[i];
        end
    end

    always_comb irq = irq_en && (ready || (|flag));
endmodule

// File: rtl/rng_stat_chk.sv
module rng_stat_chk
    import rng_stat_pkg::*;
#(
    parameter int REG_W_P = REG_W
) (
    input logic               clk,
    input logic               rst,
    input logic               seed_err_in,
    input logic               ced_off,
    input logic               sample_stb,
    input logic               data_rd,
    input logic               irq_en,
    input logic               wr_en,
    input logic [REG_W_P-1:0] wr_data,
    input logic [REG_W_P-1:0] rd_data,
    input logic               irq
);
    localparam int LC = LIVE_BASE + SRC_CLK;
    localparam int LS = LIVE_BASE + SRC_SEED;
    localparam int FC = FLAG_BASE + SRC_CLK;
    localparam int FS = FLAG_BASE + SRC_SEED;

    p_seed_live_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rd_data[LS] == $past(seed_err_in)));

    p_flag_rise_clk_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[LC]) |-> rd_data[FC]);

    // also covers R5: a set event wins over a clearing write
    p_flag_rise_seed_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_data[LS]) |-> rd_data[FS]);

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_data[FS] && !(wr_en && !wr_data[FS])) |=> rd_data[FS]);

    p_ced_mask_r6: assert property (@(posedge clk) disable iff (rst)
        ced_off |=> !rd_data[LC]);

    p_rdy_load_r7: assert property (@(posedge clk) disable iff (rst)
        sample_stb |=> rd_data[RDY_BIT]);

    p_rdy_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (data_rd && !sample_stb) |=> !rd_data[RDY_BIT]);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

    p_irq_rdy_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_en && rd_data[RDY_BIT]) |-> irq);
endmodule

bind rng_stat_reg rng_stat_chk #(.REG_W_P(REG_W_P)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .seed_err_in (seed_err_in),
    .ced_off     (ced_off),
    .sample_stb  (sample_stb),
    .data_rd     (data_rd),
    .irq_en      (irq_en),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .irq         (irq)
);

// File: tb/rng_stat_reg_test.sv
`timescale 1ns/1ps
module rng_stat_reg_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       clk_err_in, seed_err_in, ced_off, sample_stb, data_rd, irq_en, wr_en;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic m_rdy, m_lc, m_ls, m_fc, m_fs;

    always #10 clk = ~clk;

    rng_stat_reg uut (
        .clk(clk), .rst(rst), .clk_err_in(clk_err_in), .seed_err_in(seed_err_in),
        .ced_off(ced_off), .sample_stb(sample_stb), .data_rd(data_rd), .irq_en(irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(rd_data[0] == m_rdy, "R7/R8 ready", rd_data[0], m_rdy);
        chk(rd_data[1] == m_lc, "R2/R6 clock live", rd_data[1], m_lc);
        chk(rd_data[2] == m_ls, "R2 seed live", rd_data[2], m_ls);
        chk(rd_data[3] == m_fc, "R3/R4 clock flag", rd_data[3], m_fc);
        chk(rd_data[4] == m_fs, "R3/R4 seed flag", rd_data[4], m_fs);
        chk(rd_data[7:5] == 3'b000, "R11 spare bits", rd_data[7:5], 0);
        chk(irq == (irq_en & (m_rdy | m_fc | m_fs)), "R9 irq", irq,
            irq_en & (m_rdy | m_fc | m_fs));
    endtask

    // drive one cycle, update the model at the edge, compare at the falling edge
    task automatic step(input logic ce, input logic se, input logic ced, input logic smp,
                        input logic rd, input logic ie, input logic we, input logic [7:0] wd);
        logic cc;
        clk_err_in = ce; seed_err_in = se; ced_off = ced; sample_stb = smp;
        data_rd = rd; irq_en = ie; wr_en = we; wr_data = wd;
        @(posedge clk);
        if (rst) begin
            m_rdy = 0; m_lc = 0; m_ls = 0; m_fc = 0; m_fs = 0;
        end else begin
            cc = ce & ~ced;
            if (cc & ~m_lc) m_fc = 1'b1;
            else if (we & ~wd[3]) m_fc = 1'b0;
            if (se & ~m_ls) m_fs = 1'b1;
            else if (we & ~wd[4]) m_fs = 1'b0;
            m_lc = cc;
            m_ls = se;
            if (!m_rdy) m_rdy = smp;
            else if (rd & ~smp) m_rdy = 1'b0;
        end
        @(negedge clk);
        compare_all();
    endtask

    task automatic step_p(input logic [9:0] p);
        step(p[0], p[1], p[2], p[3], p[4], p[5], p[6],
             {p[9], p[8], p[7], p[8], p[7], p[1], p[0], p[9]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        m_rdy = 0; m_lc = 0; m_ls = 0; m_fc = 0; m_fs = 0;
        rst = 1'b1;
        // R1: busy inputs during reset must not leak into the register
        step(1, 1, 0, 1, 0, 1, 1, 8'h00);
        step(1, 1, 0, 1, 0, 1, 1, 8'h00);
        chk(rd_data == 8'h00, "R1 reset word", rd_data, 0);
        chk(irq == 1'b0, "R1 reset irq", irq, 0);
        step(0, 0, 0, 0, 0, 0, 0, 8'hff);
        rst = 1'b0;
        step(0, 0, 0, 0, 0, 1, 0, 8'hff);
        chk(rd_data == 8'h00, "R1 word after reset", rd_data, 0);

        // exhaustive sweep, strided order
        for (int k = 0; k < 1024; k++) step_p(10'((k * 389 + 7) % 1024));
        // exhaustive sweep, Gray order
        for (int k = 0; k < 1024; k++) step_p(10'(k ^ (k >> 1)));

        // R10: held seed fault, cleared once, must not re-set while held
        step(0, 0, 0, 0, 1, 0, 1, 8'h00);
        step(0, 1, 0, 0, 0, 0, 0, 8'h00);
        chk(rd_data[4] == 1'b1, "R3 seed flag on rise", rd_data[4], 1);
        step(0, 1, 0, 0, 0, 0, 1, 8'h00);
        chk(rd_data[4] == 1'b0, "R4 seed flag cleared", rd_data[4], 0);
        step(0, 1, 0, 0, 0, 1, 0, 8'h00);
        step(0, 1, 0, 0, 0, 1, 0, 8'h00);
        chk(rd_data[4] == 1'b0, "R10 no re-set while held", rd_data[4], 0);
        chk(irq == 1'b0, "R9 irq idle", irq, 0);

        // R5: rise together with a clearing write
        step(0, 0, 0, 0, 0, 0, 0, 8'h00);
        step(0, 1, 0, 0, 0, 0, 1, 8'h00);
        chk(rd_data[4] == 1'b1, "R5 set wins over clear", rd_data[4], 1);
        // R4: write of ones and disabled write keep the flag
        step(0, 1, 0, 0, 0, 0, 1, 8'hff);
        step(0, 1, 0, 0, 0, 0, 0, 8'h00);
        chk(rd_data[4] == 1'b1, "R4 ones and idle write keep flag", rd_data[4], 1);
        step(0, 1, 0, 0, 0, 0, 1, 8'h00);
        chk(rd_data[2] == 1'b1, "R2 live ignores write", rd_data[2], 1);

        // R6: masked clock fault
        step(1, 0, 1, 0, 0, 0, 1, 8'h00);
        step(1, 0, 1, 0, 0, 1, 0, 8'h00);
        chk(rd_data[1] == 1'b0, "R6 masked live", rd_data[1], 0);
        chk(rd_data[3] == 1'b0, "R6 masked flag", rd_data[3], 0);
        step(1, 0, 0, 0, 0, 1, 0, 8'h00);
        chk(rd_data[3:1] == 3'b101, "R6 unmask raises live and flag", rd_data[3:1], 5);
        chk(irq == 1'b1, "R9 irq from clock flag", irq, 1);
        step(0, 0, 0, 0, 0, 0, 1, 8'h00);

        // R7/R8: load, refill, drain
        step(0, 0, 0, 1, 0, 0, 0, 8'h00);
        chk(rd_data[0] == 1'b1, "R7 ready loaded", rd_data[0], 1);
        step(0, 0, 0, 1, 1, 0, 0, 8'h00);
        chk(rd_data[0] == 1'b1, "R8 read with sample keeps ready", rd_data[0], 1);
        step(0, 0, 0, 0, 1, 1, 0, 8'h00);
        chk(rd_data[0] == 1'b0, "R8 read drains ready", rd_data[0], 0);
        chk(irq == 1'b0, "R9 irq after drain", irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule